// File: doc/BRIEF.md
# Sampled Input Debouncer with Single-Cycle Edge Strobes

This block cleans up one slow, asynchronous digital input, such as a mechanical position sensor, so that logic on a fast system clock can use it. The raw input first passes through a two-flop synchronizer. A prescaler divides the system clock into a periodic sample-enable pulse, about every 10 microseconds by default. On each enable the synchronized level is shifted into a short history register. The debounced level changes only when the whole history agrees.

The block also has separate rising and falling strobes. Each strobe is high for exactly one system-clock cycle, in the cycle where the debounced level changes. Downstream logic therefore needs no edge detector of its own, even though sampling runs at the much slower enable rate. The system clock rate, the sample rate and the history depth are parameters. Elaboration checks reject settings that would make the debounce window too long to catch a 500 microsecond sensor pulse.

Top module: `sig_debounce`

## Requirements
- R1: While `rst` is high at a clock edge, the prescaler, synchronizer, history, `level_o`, `rise_o` and `fall_o` are all cleared to 0.
- R2: The history shifts in one new sample only once every DIV system-clock cycles, where DIV = CLK_HZ / SAMPLE_HZ. The shift happens at the edge where the prescaler count, started at 0 by reset, reaches DIV-1.
- R3: `din` reaches the history only through a two-stage synchronizer. A value driven before clock edge E0 is first sampled at a sample edge no earlier than E0+2.
- R4: `level_o` becomes 1 one cycle after all DEPTH history bits are 1, and becomes 0 one cycle after all of them are 0. Otherwise it holds its value.
- R5: `rise_o` is 1 for exactly one cycle, in the same cycle that `level_o` goes from 0 to 1. At no other time is it 1.
- R6: `fall_o` is 1 for exactly one cycle, in the same cycle that `level_o` goes from 1 to 0. At no other time is it 1.
- R7: An input excursion short enough to be sampled at most once, against a settled level, never changes `level_o` and raises no strobe.
- R8: `rise_o` and `fall_o` are never 1 in the same cycle.
- R9: A clean pulse lasting 500 microseconds (50 sample periods by default) gives exactly one rise strobe and one fall strobe. Elaboration fails if DEPTH times the sample period exceeds 250 microseconds.
- R10: After a clean input step, measured from the first clock edge after `din` changes and counting that edge as 1, `level_o` changes after between 4+(DEPTH-1)*DIV and 3+DEPTH*DIV edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Raw asynchronous input |
| level_o | output | 1 | Debounced level |
| rise_o | output | 1 | One-cycle strobe on a 0-to-1 change of `level_o` |
| fall_o | output | 1 | One-cycle strobe on a 1-to-0 change of `level_o` |

## Verification
The bench starts with clean steps and full 500 microsecond pulses. These show the latency window and the one-rise, one-fall count. Pulses and dips exactly one sample period long, and very short spikes, separate a filter that requires a unanimous history from one that reacts to a single contrary sample. Random bursts of bounce with random settling times, all from a fixed seed, put transitions at every prescaler phase. A cycle-by-cycle reference built from the requirements catches strobes that come one cycle early, one cycle late, or are stretched over the sample period.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
   } dbn_edge_t;

   function automatic int dbn_ratio(input longint clk_hz, input longint smp_hz);
      return int'(clk_hz / smp_hz);
   endfunction

   function automatic longint dbn_window_ns(input int depth, input longint smp_hz);
      return (longint'(depth) * 64'd1_000_000_000) / smp_hz;
   endfunction

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dbn_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain_q[0] <= 1'b0;
            else     chain_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dbn_prescale.sv
module dbn_prescale #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   if (DIV < 1) begin : g_bad_div
      $error("dbn_prescale: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick = 1'b1;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (rst)               cnt_q <= '0;
         else if (cnt_q == LAST) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);
   end
endmodule

// File: rtl/dbn_filter.sv
module dbn_filter #(
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             smp,
   output logic [DEPTH-1:0] hist_q,
   output logic             level_d,
   output logic             level_q
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("dbn_filter: DEPTH must be at least 2");
   end

   logic all_hi;
   logic all_lo;

   always_ff @(posedge clk) begin
      if (rst)       hist_q <= '0;
      else if (tick) hist_q <= {hist_q[DEPTH-2:0], smp};
   end

   assign all_hi = &hist_q;
   assign all_lo = ~|hist_q;

   always_comb begin
      level_d = level_q;
      if (all_hi)      level_d = 1'b1;
      else if (all_lo) level_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) level_q <= 1'b0;
      else     level_q <= level_d;
   end
endmodule

// File: rtl/dbn_edge.sv
module dbn_edge
   import dbn_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      level_d,
   input  logic      level_q,
   output dbn_edge_t strobe_q
);
   dbn_edge_t strobe_d;

   always_comb begin
      strobe_d.rise = level_d & ~level_q;
      strobe_d.fall = ~level_d & level_q;
   end

   always_ff @(posedge clk) begin
      if (rst) strobe_q <= '0;
      else     strobe_q <= strobe_d;
   end
endmodule

// File: rtl/sig_debounce.sv
module sig_debounce
   import dbn_pkg::*;
#(
   parameter longint CLK_HZ      = 10_000_000,
   parameter longint SAMPLE_HZ   = 100_000,
   parameter int     DEPTH       = 4,
   parameter int     SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   localparam int     DIV       = dbn_ratio(CLK_HZ, SAMPLE_HZ);
   localparam longint WINDOW_NS = dbn_window_ns(DEPTH, SAMPLE_HZ);
   localparam longint MAX_WIN   = 250_000;

   if (SAMPLE_HZ <= 0 || CLK_HZ < SAMPLE_HZ) begin : g_bad_rate
      $error("sig_debounce: need 0 < SAMPLE_HZ <= CLK_HZ");
   end
   if (WINDOW_NS > MAX_WIN) begin : g_bad_window
      $error("sig_debounce: DEPTH * sample period exceeds 250 us (R9)");
   end

   logic             smp_sync;
   logic             smp_tick;
   logic [DEPTH-1:0] hist_q;
   logic             level_d;
   logic             level_q;
   dbn_edge_t        strobe;

   dbn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (din),
      .q   (smp_sync)
   );

   dbn_prescale #(.DIV(DIV)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .tick (smp_tick)
   );

   dbn_filter #(.DEPTH(DEPTH)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .tick    (smp_tick),
      .smp     (smp_sync),
      .hist_q  (hist_q),
      .level_d (level_d),
      .level_q (level_q)
   );

   dbn_edge u_edge (
      .clk      (clk),
      .rst      (rst),
      .level_d  (level_d),
      .level_q  (level_q),
      .strobe_q (strobe)
   );

   assign level_o = level_q;
   assign rise_o  = strobe.rise;
   assign fall_o  = strobe.fall;
endmodule

// File: rtl/sig_debounce_chk.sv
module sig_debounce_chk #(
   parameter int DEPTH = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic [DEPTH-1:0] hist,
   input logic             level,
   input logic             rise,
   input logic             fall
);
   p_shift_gated_r2: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(hist));

   p_set_unanimous_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(level) |-> (&$past(hist)));

   p_clr_unanimous_r4: assert property (@(posedge clk) disable iff (rst)
      $fell(level) |-> (~|$past(hist)));

   p_hold_mixed_r4: assert property (@(posedge clk) disable iff (rst)
      ((|hist) && !(&hist)) |=> $stable(level));

   p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);

   p_rise_on_flip_r5: assert property (@(posedge clk) disable iff (rst)
      rise |-> (level && !$past(level)));

   p_fall_single_r6: assert property (@(posedge clk) disable iff (rst)
      fall |=> !fall);

   p_fall_on_flip_r6: assert property (@(posedge clk) disable iff (rst)
      fall |-> (!level && $past(level)));

   p_flip_strobed_r5: assert property (@(posedge clk) disable iff (rst)
      (level != $past(level)) |-> (rise || fall));

   p_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(rise && fall));
endmodule

bind sig_debounce sig_debounce_chk #(.DEPTH(DEPTH)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .tick  (smp_tick),
   .hist  (hist_q),
   .level (level_o),
   .rise  (rise_o),
   .fall  (fall_o)
);

// File: tb/sig_debounce_tb.sv
module sig_debounce_tb;
   localparam longint CLK_HZ    = 400_000;
   localparam longint SAMPLE_HZ = 100_000;
   localparam int     DEPTH     = 4;
   localparam int     DIV       = 4;
   localparam int     PULSE     = 50 * DIV;
   localparam int     LAT_LO    = 4 + (DEPTH - 1) * DIV;
   localparam int     LAT_HI    = 3 + DEPTH * DIV;
   localparam int     SETTLE    = LAT_HI + 4;
   localparam int     WD_LIMIT  = 150_000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic din = 1'b0;
   logic level_o, rise_o, fall_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int n_rise = 0;
   int n_fall = 0;
   bit done   = 1'b0;
   bit prev_rise = 1'b0;
   bit prev_fall = 1'b0;

   always #4 clk = ~clk;

   sig_debounce #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ), .DEPTH(DEPTH)) u_dut (
      .clk     (clk),
      .rst     (rst),
      .din     (din),
      .level_o (level_o),
      .rise_o  (rise_o),
      .fall_o  (fall_o)
   );

   // Reference model built from R1..R6
   logic             m_s1, m_s2, m_lvl, m_rise, m_fall;
   logic [DEPTH-1:0] m_hist;
   int               m_cnt;

   function automatic logic exp_level(input logic [DEPTH-1:0] h, input logic cur);
      if (h == '1) return 1'b1;
      if (h == '0) return 1'b0;
      return cur;
   endfunction

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rst) begin
         m_s1 <= 0; m_s2 <= 0; m_cnt <= 0; m_hist <= '0;
         m_lvl <= 0; m_rise <= 0; m_fall <= 0;
      end else begin
         m_s1 <= din;
         m_s2 <= m_s1;
         m_cnt <= (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
         if (m_cnt == DIV - 1) m_hist <= {m_hist[DEPTH-2:0], m_s2};
         m_lvl  <= exp_level(m_hist, m_lvl);
         m_rise <= exp_level(m_hist, m_lvl) & ~m_lvl;
         m_fall <= ~exp_level(m_hist, m_lvl) & m_lvl;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst && !done) begin
         chk(level_o == m_lvl, "R4 level", level_o, m_lvl);
         chk(rise_o == m_rise, "R5 rise", rise_o, m_rise);
         chk(fall_o == m_fall, "R6 fall", fall_o, m_fall);
         chk(!(rise_o && fall_o), "R8 exclusive", rise_o & fall_o, 0);
         if (prev_rise) chk(!rise_o, "R5 width", rise_o, 0);
         if (prev_fall) chk(!fall_o, "R6 width", fall_o, 0);
         prev_rise = rise_o;
         prev_fall = fall_o;
         if (rise_o) n_rise++;
         if (fall_o) n_fall++;
      end
   end

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic step_latency(input logic v, input string req);
      int n = 0;
      @(negedge clk);
      din = v;
      while (n < LAT_HI + 8) begin
         @(negedge clk);
         n++;
         if (level_o == v) break;
      end
      chk(n >= LAT_LO && n <= LAT_HI, req, n, LAT_LO);
   endtask

   task automatic summary;
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      int r0, f0, tmp;
      tmp = $urandom(32'd1234);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(level_o == 0, "R1 level", level_o, 0);
      chk(rise_o == 0, "R1 rise", rise_o, 0);
      chk(fall_o == 0, "R1 fall", fall_o, 0);
      rst = 1'b0;
      hold(SETTLE);

      // R10 latency for clean steps at several prescaler phases
      for (int ph = 0; ph < DIV; ph++) begin
         hold(ph);
         step_latency(1'b1, "R10 rise latency");
         hold(SETTLE);
         step_latency(1'b0, "R10 fall latency");
         hold(SETTLE + ph);
      end

      // R9: clean 500 us pulse
      r0 = n_rise; f0 = n_fall;
      din = 1'b1; hold(PULSE); din = 1'b0; hold(SETTLE);
      chk(n_rise - r0 == 1, "R9 pulse rise count", n_rise - r0, 1);
      chk(n_fall - f0 == 1, "R9 pulse fall count", n_fall - f0, 1);

      // R7: one-sample and sub-sample excursions, both polarities, all phases
      for (int ph = 0; ph < DIV; ph++) begin
         r0 = n_rise; f0 = n_fall;
         hold(ph); din = 1'b1; hold(DIV); din = 1'b0; hold(SETTLE);
         din = 1'b1; hold(1); din = 1'b0; hold(SETTLE);
         chk(n_rise == r0 && n_fall == f0, "R7 high glitch", n_rise - r0, 0);
         chk(level_o == 0, "R7 level stays low", level_o, 0);
      end
      din = 1'b1; hold(SETTLE);
      for (int ph = 0; ph < DIV; ph++) begin
         r0 = n_rise; f0 = n_fall;
         hold(ph); din = 1'b0; hold(DIV); din = 1'b1; hold(SETTLE);
         chk(n_rise == r0 && n_fall == f0, "R7 low glitch", n_fall - f0, 0);
         chk(level_o == 1, "R7 level stays high", level_o, 1);
      end

      // Random bounce bursts, then settling (R2, R3, R4 via reference model)
      for (int it = 0; it < 60; it++) begin
         int bursts = 1 + ($urandom % 12);
         for (int b = 0; b < bursts; b++) begin
            din = ~din;
            hold(1 + ($urandom % 3));
         end
         din = $urandom % 2;
         hold(SETTLE + ($urandom % 40));
         chk(level_o == din, "R4 settled level", level_o, din);
      end

      // R1: reset mid-operation clears outputs
      din = 1'b1; hold(SETTLE);
      rst = 1'b1; hold(2);
      chk(level_o == 0 && rise_o == 0 && fall_o == 0, "R1 reset again", level_o, 0);
      rst = 1'b0; din = 1'b0; hold(SETTLE);
      summary();
   end

   initial begin
      wait (cycles >= WD_LIMIT);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
         summary();
      end
   end
endmodule